// File: doc/BRIEF.md
# Dual-Clock Line-Delay Buffer

This block stores one scan line of pixel data, up to 5,048 bytes, and plays it back on a second clock. It serves two jobs: delaying a stream by a fixed number of words, and moving a stream between two unrelated clock rates. The write side and the read side each have their own clock, enable, reset and address counter. Neither port watches the other, and there are no full or empty indications.

The distance between the writer and the reader is set only by when the two resets are issued. A read reset given N words after a write reset yields a stream that lags the input by N words. Each counter returns to address zero only through its own reset. The read data leaves through a register, together with a drive-enable flag that stands in for a three-state output.

Top module: `line_delay_buffer`

## Requirements
- R1: A write-clock edge with `wr_en`=1 and `wr_rst`=0 stores `wr_data` at the current write address and advances that address by one.
- R2: A write-clock edge with `wr_rst`=1 sets the write address to 0 and stores nothing, whatever `wr_en` is. Holding `wr_rst` over many edges keeps the address at 0, so the first word written after release lands in word 0.
- R3: A write-clock edge with `wr_en`=0 changes no stored word and leaves the write address unchanged.
- R4: One read-clock edge with `rd_rst`=1 sets the read address to 0. Any number of further reset edges keep it there, and `rd_data` keeps its previous value on every reset edge.
- R5: After a read reset, successive read-clock edges with `rd_en`=1 present word 0, word 1, word 2 and so on in `rd_data`, each one after the edge that fetched it.
- R6: A read-clock edge with `rd_en`=0 leaves both the read address and `rd_data` unchanged.
- R7: `rd_drive` is 1 after a read-clock edge that sampled `rd_en`=1 and 0 after one that sampled `rd_en`=0. The value 0 means the output is undriven (high impedance).
- R8: Both addresses run from 0 to 5,047 and step from 5,047 back to 0.
- R9: With both clocks at the same rate, issue a read reset after N words (21 <= N <= 5,048) have been written since the write reset, then read continuously. `rd_data` then repeats the written stream N words later.
- R10: The two clocks may differ in rate and phase. A word written on a write edge can be read on any later read edge that fetches its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_en | input | 1 | Write enable, active high |
| wr_rst | input | 1 | Write address reset, synchronous, active high |
| wr_data | input | 8 | Word to store |
| rd_clk | input | 1 | Read-side clock |
| rd_en | input | 1 | Read enable, active high |
| rd_rst | input | 1 | Read address reset, synchronous, active high |
| rd_data | output | 8 | Registered read word |
| rd_drive | output | 1 | 1 while the output is driven, 0 for high impedance |

## Verification
The bench runs the writer and reader on unrelated clocks. It targets several faults:
- Reset held across several edges: a counter that slips while held shifts every following word by one.
- The minimum delay of 21 words.
- A full pass across the 5,047-to-0 wrap: an off-by-one limit corrupts the second line.
- Enables toggled word by word on both sides: a write that ignores its enable would overwrite stored words, and a read that advances while disabled would skip data.
- A reader slower than the writer: a design that depended on matched rates would show up here.

// File: rtl/line_delay_buffer.sv
module line_delay_buffer #(
  parameter int DEPTH = 5048,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             wr_clk,
  input  logic             wr_en,
  input  logic             wr_rst,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_clk,
  input  logic             rd_en,
  input  logic             rd_rst,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_drive
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_addr, rd_addr;

  wire [AW-1:0] wr_next = (wr_addr == LAST) ? '0 : wr_addr + AW'(1);
  wire [AW-1:0] rd_next = (rd_addr == LAST) ? '0 : rd_addr + AW'(1);
  wire          wr_go   = wr_en & ~wr_rst;
  wire          rd_go   = rd_en & ~rd_rst;

  always_ff @(posedge wr_clk) begin
    if (wr_rst)     wr_addr <= '0;
    else if (wr_en) wr_addr <= wr_next;
  end

  always_ff @(posedge wr_clk) begin
    if (wr_go) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge rd_clk) begin
    rd_drive <= rd_en;
    if (rd_rst) rd_addr <= '0;
    else if (rd_go) begin
      rd_addr <= rd_next;
      rd_data <= mem[rd_addr];
    end
  end

  a_r1_wr_step: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_en && wr_addr != LAST) |=> wr_addr == $past(wr_addr) + AW'(1));
  a_r2_wr_release_zero: assert property (@(posedge wr_clk) disable iff (wr_rst)
    $fell(wr_rst) |-> wr_addr == '0);
  a_r3_wr_hold: assert property (@(posedge wr_clk) disable iff (wr_rst)
    !wr_en |=> $stable(wr_addr));
  a_r8_wr_wrap: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_en && wr_addr == LAST) |=> wr_addr == '0);

  a_r4_rd_release_zero: assert property (@(posedge rd_clk) disable iff (rd_rst)
    $fell(rd_rst) |-> rd_addr == '0);
  a_r6_rd_hold: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !rd_en |=> ($stable(rd_addr) && $stable(rd_data)));
  a_r7_drive_on: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_en |=> rd_drive);
  a_r7_drive_off: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !rd_en |=> !rd_drive);
  a_r8_rd_wrap: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_en && rd_addr == LAST) |=> rd_addr == '0);

endmodule

// File: tb/line_delay_buffer_bench.sv
`timescale 1ns/1ps
module line_delay_buffer_bench;
  localparam int DEPTH = 5048;

  logic       wr_clk = 0, rd_clk = 0;
  logic       wr_en = 0, wr_rst = 1, rd_en = 0, rd_rst = 1;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic       rd_drive;
  real        rd_half = 2.5;

  int vectors = 0, fails = 0;
  string phase_tag = "R4 R7";

  int  model_mem [DEPTH];
  int  m_wp = 0, m_rp = 0, words_since_wrst = 0, exp_data = -1;
  bit  exp_drive = 0, model_started = 0;
  int  ramp = 0;

  line_delay_buffer u_line_delay_buffer (
    .wr_clk(wr_clk), .wr_en(wr_en), .wr_rst(wr_rst), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_en(rd_en), .rd_rst(rd_rst),
    .rd_data(rd_data), .rd_drive(rd_drive));

  initial forever #2.5 wr_clk = ~wr_clk;
  initial begin #1.3; forever #(rd_half) rd_clk = ~rd_clk; end

  initial for (int i = 0; i < DEPTH; i++) model_mem[i] = -1;

  always @(posedge wr_clk) begin
    if (wr_rst) begin m_wp = 0; words_since_wrst = 0; end
    else if (wr_en) begin
      model_mem[m_wp] = wr_data;
      m_wp = (m_wp == DEPTH - 1) ? 0 : m_wp + 1;
      words_since_wrst++;
    end
  end

  always @(posedge rd_clk) begin
    model_started = 1;
    if (rd_rst) m_rp = 0;
    else if (rd_en) begin
      exp_data = model_mem[m_rp];
      m_rp = (m_rp == DEPTH - 1) ? 0 : m_rp + 1;
    end
    exp_drive = rd_en;
  end

  always @(negedge rd_clk) if (model_started) begin
    vectors++;
    if (rd_drive !== exp_drive) begin
      fails++;
      $display("FAIL %s rd_drive actual %0b expected %0b at %0t", phase_tag, rd_drive, exp_drive, $time);
    end else if (exp_drive && exp_data >= 0 && rd_data !== exp_data[7:0]) begin
      fails++;
      $display("FAIL %s rd_data actual %0d expected %0d at %0t", phase_tag, rd_data, exp_data, $time);
    end
  end

  task automatic check(bit ok, string tag, int act, int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic wr_reset(int edges);
    @(negedge wr_clk);
    wr_rst = 1; wr_en = 1; wr_data = 8'hA5; ramp = 0;
    for (int i = 1; i < edges; i++) begin
      @(negedge wr_clk);
      wr_data = wr_data + 8'd1;
    end
  endtask

  task automatic write_stream(int n, int duty);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_rst = 0;
      wr_en = (duty == 0) || (i % duty != 0);
      if (wr_en) begin wr_data = ramp[7:0]; ramp++; end
      else wr_data = 8'h5A;
    end
    @(negedge wr_clk);
    wr_en = 0;
  endtask

  task automatic read_stream(int delay, int rst_edges, int n, int duty, bit ramp_chk, string tag);
    int  k = 0;
    bit  pending = 0;
    @(posedge wr_rst);
    @(negedge wr_clk);
    wait (words_since_wrst >= delay);
    @(negedge rd_clk);
    rd_rst = 1; rd_en = 1;
    for (int i = 1; i < rst_edges; i++) @(negedge rd_clk);
    for (int i = 0; i < n; i++) begin
      @(negedge rd_clk);
      rd_rst = 0;
      if (pending && ramp_chk)
        check(rd_data === 8'((k - 1) % 256), tag, rd_data, (k - 1) % 256);
      rd_en = (duty == 0) || (i % duty != 0);
      pending = rd_en;
      if (rd_en) k++;
    end
    @(negedge rd_clk);
    if (pending && ramp_chk)
      check(rd_data === 8'((k - 1) % 256), tag, rd_data, (k - 1) % 256);
    rd_en = 0;
  endtask

  initial begin
    repeat (4) @(negedge wr_clk);
    check(rd_drive === 1'b0, "R7 reset state", rd_drive, 0);
    wr_rst = 0; rd_rst = 0;
    repeat (2) @(negedge wr_clk);

    phase_tag = "R1 R5 R9";
    fork
      begin wr_reset(1); write_stream(300, 0); end
      read_stream(40, 1, 200, 0, 1, "R5 R9 delay 40");
    join

    phase_tag = "R2 R4";
    fork
      begin wr_reset(5); write_stream(400, 0); end
      read_stream(21, 6, 300, 0, 1, "R2 R4 R9 delay 21");
    join

    phase_tag = "R3 R6 R7";
    fork
      begin wr_reset(1); write_stream(600, 3); end
      read_stream(30, 1, 300, 4, 0, "R6");
    join

    phase_tag = "R8";
    fork
      begin wr_reset(1); write_stream(DEPTH + 300, 0); end
      read_stream(25, 1, DEPTH + 200, 0, 1, "R8 wrap");
    join

    phase_tag = "R10";
    rd_half = 3.5;
    fork
      begin wr_reset(1); write_stream(800, 0); end
      read_stream(50, 1, 500, 0, 1, "R10 slow reader");
    join

    repeat (4) @(negedge rd_clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(100000 * 5.0);
    fails++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule